// File: doc/BRIEF.md
# Byte-Addressable Word Data Memory Controller

This block is the data-side memory access unit of a 16-bit processor whose data space is addressed by byte. A request carries a 16-bit effective address, a size flag (byte or word), a read strobe, a write strobe and 16 bits of write data. The storage behind it is two byte-wide banks. They share one word-index decoder, and each has its own write enable. A byte access goes to the bank picked by address bit 0. A word access uses both banks together.

The block steers byte reads onto the low lane and zeroes the upper lane. It detects word accesses to odd addresses and reports them as a registered one-cycle trap that carries the faulting address. A faulting write is blocked, but a faulting read still returns data. Any address outside the implemented RAM reads as zero and ignores writes. This covers the low register window (0x0000 to 0x07FF, which holds no registers here), the RAM-less space above the RAM, and the reserved half where bit 15 is set. A combinational helper gives the next value of a post-incremented pointer for the current request size.

Top module: `dmem_ctrl`

## Requirements
- R1: A word write to an even address inside the RAM stores wdata[7:0] at that address and wdata[15:8] at address+1. A later word read of the same address returns both bytes in the same positions. Read data and rd_valid appear exactly one clock edge after the edge that accepts the read.
- R2: A byte write (req_word=0) takes its data from wdata[7:0]. It changes only the byte at its address: the low bank when address bit 0 is 0, the high bank when it is 1. The other byte of that word keeps its value.
- R3: A byte read returns the selected byte on rd_data[7:0] and forces rd_data[15:8] to zero.
- R4: A word write to an odd address modifies no memory byte.
- R5: A word read from an odd address still completes. rd_valid is asserted and rd_data is the word at the address with bit 0 cleared.
- R6: A word access (read or write) to an odd address drives trap high for exactly one cycle, one edge after acceptance. In that same cycle trap_addr equals the faulting address. Accesses that do not fault never raise trap.
- R7: Addresses with bit 15 set read as zero, and writes to them change nothing.
- R8: Addresses 0x0000 to 0x07FF read as zero, and writes to them change nothing.
- R9: Addresses from 0x0800+RAM_BYTES up to 0x7FFF read as zero, and writes to them change nothing.
- R10: ptr_next equals req_addr+1 for a byte request and req_addr+2 for a word request, modulo 2^16, and is combinational.
- R11: After reset, rd_valid, trap, trap_addr and rd_data are all zero. rd_data is also zero in every cycle in which rd_valid is low.
- R12: When req_rd and req_wr are both high, the write is performed and the read is dropped, so rd_valid stays low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_addr | input | 16 | Byte effective address |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_rd | input | 1 | Read strobe |
| req_wr | input | 1 | Write strobe |
| req_wdata | input | 16 | Write data (bytes use bits 7:0) |
| rd_data | output | 16 | Read data, zero unless rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after request |
| trap | output | 1 | Address-error pulse |
| trap_addr | output | 16 | Address of the last faulting access |
| ptr_next | output | 16 | Post-increment pointer value |

## Verification
A wrong bank write enable shows up as a corrupted neighbour byte, or a missing byte, on the next read of that word. That is one request plus one cycle of latency after the bad write. A wrong region decode shows as non-zero data from a hole, or as a RAM byte changed after a write to a hole, and the bench reads the RAM back after such writes. A stale or misrouted trap flag shows in the cycle directly after the request, as a missing, doubled or wrongly addressed trap pulse.

// File: rtl/dmem_pkg.sv
// Shared types for the data memory controller.
// Assumes a 16-bit byte address and a 16-bit data word made of two byte lanes.
package dmem_pkg;
    localparam int LANE_W = 8;
    localparam int DATA_W = 2 * LANE_W;

    // Per-request attributes held across the one-cycle read latency
    typedef struct packed {
        logic valid;
        logic word;
        logic lsb;
        logic in_ram;
    } rd_ctx_t;
endpackage

// File: rtl/dmem_decode.sv
// Address classifier: decides whether a byte address hits backed RAM,
// whether a word request is misaligned, and which word row it selects.
// Assumes RAM_BASE is even and RAM_BYTES a power of two.
module dmem_decode #(
    parameter int ADDR_W    = 16,
    parameter int RAM_BASE  = 'h0800,
    parameter int RAM_BYTES = 2048,
    parameter int IDX_W     = 10
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              word,
    output logic              in_ram,
    output logic              misalign,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [ADDR_W:0] LO_B = (ADDR_W+1)'(RAM_BASE);
    localparam logic [ADDR_W:0] HI_B = (ADDR_W+1)'(RAM_BASE + RAM_BYTES);

    logic [ADDR_W-1:0] offset;

    // Region test, alignment test and row index
    always_comb begin
        in_ram   = !addr[ADDR_W-1] && ({1'b0, addr} >= LO_B) && ({1'b0, addr} < HI_B);
        misalign = word && addr[0];
        offset   = addr - ADDR_W'(RAM_BASE);
        idx      = offset[IDX_W:1];
    end
endmodule

// File: rtl/dmem_bank.sv
// One byte-wide storage bank with a synchronous write and a registered read.
// Assumes the caller has already qualified the write enable.
module dmem_bank #(
    parameter int DEPTH = 1024,
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             we,
    input  logic             re,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata
);
    logic [7:0] mem [DEPTH];

    // Store a byte and capture the addressed byte on a read
    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wdata;
        if (re) rdata <= mem[idx];
    end
endmodule

// File: rtl/dmem_steer.sv
// Read lane steering: selects the byte for byte reads onto the low lane,
// zeroes the upper lane, and returns zero for unbacked addresses.
// Assumes ctx is the registered context of the read being returned.
module dmem_steer
    import dmem_pkg::*;
(
    input  rd_ctx_t           ctx,
    input  logic [LANE_W-1:0] lo,
    input  logic [LANE_W-1:0] hi,
    output logic [DATA_W-1:0] data
);
    // Lane mux with zero fill
    always_comb begin
        data = '0;
        if (ctx.valid && ctx.in_ram) begin
            if (ctx.word)     data = {hi, lo};
            else if (ctx.lsb) data = {{LANE_W{1'b0}}, hi};
            else              data = {{LANE_W{1'b0}}, lo};
        end
    end
endmodule

// File: rtl/dmem_ctrl.sv
// Byte-addressed word data memory controller: two byte banks behind a shared
// row decode, alignment trap, zero-fill of holes and a pointer step helper.
// Assumes one request per cycle; a write wins over a simultaneous read.
module dmem_ctrl
    import dmem_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int RAM_BASE  = 'h0800,
    parameter int RAM_BYTES = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_word,
    input  logic              req_rd,
    input  logic              req_wr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              trap,
    output logic [ADDR_W-1:0] trap_addr,
    output logic [ADDR_W-1:0] ptr_next
);
    localparam int ROWS  = RAM_BYTES / 2;
    localparam int IDX_W = $clog2(ROWS);

    logic             in_ram, misalign, rd_eff;
    logic [IDX_W-1:0] idx;
    logic [1:0]       lane_we;
    logic [LANE_W-1:0] lane_wd [2];
    logic [LANE_W-1:0] lane_rd [2];
    rd_ctx_t          ctx_q;

    dmem_decode #(
        .ADDR_W(ADDR_W), .RAM_BASE(RAM_BASE), .RAM_BYTES(RAM_BYTES), .IDX_W(IDX_W)
    ) u_dec (
        .addr(req_addr), .word(req_word),
        .in_ram(in_ram), .misalign(misalign), .idx(idx)
    );

    // Write enables per lane, qualified by region and alignment
    always_comb begin
        rd_eff     = req_rd && !req_wr;
        lane_we[0] = req_wr && in_ram && !misalign && (req_word || !req_addr[0]);
        lane_we[1] = req_wr && in_ram && !misalign && (req_word ||  req_addr[0]);
        lane_wd[0] = req_wdata[LANE_W-1:0];
        lane_wd[1] = req_word ? req_wdata[DATA_W-1:LANE_W] : req_wdata[LANE_W-1:0];
    end

    for (genvar g = 0; g < 2; g++) begin : g_lane
        dmem_bank #(.DEPTH(ROWS), .IDX_W(IDX_W)) u_bank (
            .clk(clk), .we(lane_we[g]), .re(rd_eff && in_ram),
            .idx(idx), .wdata(lane_wd[g]), .rdata(lane_rd[g])
        );
    end

    // Hold the read context for the returning cycle
    always_ff @(posedge clk) begin
        if (!rst_n) ctx_q <= '0;
        else begin
            ctx_q.valid  <= rd_eff;
            ctx_q.word   <= req_word;
            ctx_q.lsb    <= req_addr[0];
            ctx_q.in_ram <= in_ram;
        end
    end

    // Trap pulse and fault address capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap      <= 1'b0;
            trap_addr <= '0;
        end else begin
            trap <= misalign && (req_rd || req_wr);
            if (misalign && (req_rd || req_wr)) trap_addr <= req_addr;
        end
    end

    dmem_steer u_steer (.ctx(ctx_q), .lo(lane_rd[0]), .hi(lane_rd[1]), .data(rd_data));

    // Post-increment pointer step
    always_comb begin
        rd_valid = ctx_q.valid;
        ptr_next = req_addr + (req_word ? ADDR_W'(2) : ADDR_W'(1));
    end

    p_trap_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> $past(req_word && req_addr[0] && (req_rd || req_wr)));
    p_trap_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> trap_addr == $past(req_addr));
    p_valid_src_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(req_rd && !req_wr));
    p_byte_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(!req_word)) |-> rd_data[DATA_W-1:LANE_W] == '0);
    p_hole_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(!in_ram)) |-> rd_data == '0);
    p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> rd_data == '0);
    p_no_misaligned_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_wr && req_word && req_addr[0]) |-> lane_we == 2'b00);
    p_dual_lane_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (&lane_we) |-> req_word);
endmodule

// File: tb/dmem_ctrl_bench.sv
module dmem_ctrl_bench;
    localparam int RAM_BASE  = 'h0800;
    localparam int RAM_BYTES = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_word = 1'b0, req_rd = 1'b0, req_wr = 1'b0;
    logic [15:0] req_wdata = '0;
    logic [15:0] rd_data, trap_addr, ptr_next;
    logic        rd_valid, trap;

    int total = 0;
    int bad = 0;
    logic [7:0] ref_mem [RAM_BYTES];

    always #2.5 clk = ~clk;

    dmem_ctrl #(.RAM_BASE(RAM_BASE), .RAM_BYTES(RAM_BYTES)) u_dmem_ctrl (
        .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .req_word(req_word),
        .req_rd(req_rd), .req_wr(req_wr), .req_wdata(req_wdata),
        .rd_data(rd_data), .rd_valid(rd_valid), .trap(trap),
        .trap_addr(trap_addr), .ptr_next(ptr_next)
    );

    function automatic bit in_ram(input logic [15:0] a);
        return (a < 16'h8000) && (int'(a) >= RAM_BASE) && (int'(a) < RAM_BASE + RAM_BYTES);
    endfunction

    function automatic logic [15:0] exp_read(input logic [15:0] a, input bit w);
        logic [15:0] ae;
        ae = {a[15:1], 1'b0};
        if (!in_ram(a)) return 16'h0;
        if (w) return {ref_mem[int'(ae) - RAM_BASE + 1], ref_mem[int'(ae) - RAM_BASE]};
        return {8'h00, ref_mem[int'(a) - RAM_BASE]};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One request: drive at negedge, sample one edge later at the next negedge
    task automatic access(input logic [15:0] a, input bit w, input bit rd, input bit wr,
                          input logic [15:0] d, output logic [15:0] q,
                          output bit v, output bit t, output logic [15:0] ta);
        @(negedge clk);
        req_addr = a; req_word = w; req_rd = rd; req_wr = wr; req_wdata = d;
        @(negedge clk);
        q = rd_data; v = rd_valid; t = trap; ta = trap_addr;
        req_rd = 1'b0; req_wr = 1'b0;
        if (wr && in_ram(a) && !(w && a[0])) begin
            if (w) begin
                ref_mem[int'(a) - RAM_BASE]     = d[7:0];
                ref_mem[int'(a) - RAM_BASE + 1] = d[15:8];
            end else ref_mem[int'(a) - RAM_BASE] = d[7:0];
        end
    endtask

    task automatic wr_op(input logic [15:0] a, input bit w, input logic [15:0] d, input string tag);
        logic [15:0] q, ta; bit v, t;
        access(a, w, 1'b0, 1'b1, d, q, v, t, ta);
        chk(t == (w && a[0]), {tag, " trap on write"}, 16'(t), 16'(w && a[0]));
        chk(!v, {tag, " no valid on write"}, 16'(v), 16'h0);
    endtask

    task automatic rd_chk(input logic [15:0] a, input bit w, input string tag);
        logic [15:0] q, ta, e; bit v, t;
        e = exp_read(a, w);
        access(a, w, 1'b1, 1'b0, 16'h0, q, v, t, ta);
        chk(v, {tag, " rd_valid"}, 16'(v), 16'h1);
        chk(q == e, {tag, " data"}, q, e);
        chk(t == (w && a[0]), {tag, " trap"}, 16'(t), 16'(w && a[0]));
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(!rd_valid && !trap, "R11 reset flags", {14'h0, rd_valid, trap}, 16'h0);
        chk(trap_addr == 0, "R11 reset trap_addr", trap_addr, 16'h0);
        chk(rd_data == 0, "R11 reset rd_data", rd_data, 16'h0);
    endtask

    task automatic t_fill;
        for (int i = 0; i < RAM_BYTES; i += 2)
            wr_op(16'(RAM_BASE + i), 1'b1, 16'(i * 16'h0137 + 16'h5a3c), "R1 fill");
    endtask

    task automatic t_word_rw;
        wr_op(16'h0810, 1'b1, 16'hbeef, "R1");
        rd_chk(16'h0810, 1'b1, "R1 word");
        rd_chk(16'h0810, 1'b0, "R1 low byte");
        rd_chk(16'h0811, 1'b0, "R1 high byte");
        wr_op(16'(RAM_BASE + RAM_BYTES - 2), 1'b1, 16'h1234, "R1 top");
        rd_chk(16'(RAM_BASE + RAM_BYTES - 2), 1'b1, "R1 top word");
        @(negedge clk);
        chk(!rd_valid && rd_data == 0, "R11 idle data", rd_data, 16'h0);
    endtask

    task automatic t_byte_lanes;
        wr_op(16'h0820, 1'b1, 16'haabb, "R2 setup");
        wr_op(16'h0820, 1'b0, 16'hff11, "R2 low");
        rd_chk(16'h0820, 1'b1, "R2 low lane only");
        wr_op(16'h0821, 1'b0, 16'hee22, "R2 high");
        rd_chk(16'h0820, 1'b1, "R2 high lane only");
        rd_chk(16'h0821, 1'b0, "R3 odd byte read");
        rd_chk(16'h0900, 1'b0, "R3 even byte read");
    endtask

    task automatic t_misaligned;
        logic [15:0] q, ta, e; bit v, t;
        wr_op(16'h0830, 1'b1, 16'h4455, "R4 setup");
        access(16'h0831, 1'b1, 1'b0, 1'b1, 16'h9999, q, v, t, ta);
        chk(t && ta == 16'h0831, "R6 write trap addr", ta, 16'h0831);
        @(negedge clk);
        chk(!trap, "R6 single pulse", 16'(trap), 16'h0);
        rd_chk(16'h0830, 1'b1, "R4 memory unchanged");
        e = exp_read(16'h0831, 1'b1);
        access(16'h0831, 1'b1, 1'b1, 1'b0, 16'h0, q, v, t, ta);
        chk(v && q == e, "R5 misaligned read data", q, e);
        chk(t && ta == 16'h0831, "R6 read trap addr", ta, 16'h0831);
        access(16'h0001, 1'b1, 1'b1, 1'b0, 16'h0, q, v, t, ta);
        chk(t && ta == 16'h0001 && q == 0, "R6 trap in hole", ta, 16'h0001);
        rd_chk(16'h0833, 1'b0, "R6 odd byte no trap");
    endtask

    task automatic t_holes;
        wr_op(16'h8800, 1'b1, 16'h7777, "R7 write");
        rd_chk(16'h8800, 1'b1, "R7 reserved read");
        rd_chk(16'h0800, 1'b1, "R7 ram untouched");
        rd_chk(16'hfffe, 1'b1, "R7 top read");
        wr_op(16'h0000, 1'b1, 16'h1111, "R8 write");
        rd_chk(16'h0000, 1'b1, "R8 reg read");
        rd_chk(16'h07ff, 1'b0, "R8 reg last byte");
        rd_chk(16'h0800, 1'b1, "R8 ram untouched");
        wr_op(16'(RAM_BASE + RAM_BYTES), 1'b1, 16'h2222, "R9 write");
        rd_chk(16'(RAM_BASE + RAM_BYTES), 1'b1, "R9 above ram");
        rd_chk(16'h7ffe, 1'b1, "R9 last hole");
        rd_chk(16'h0800, 1'b1, "R9 ram untouched");
    endtask

    task automatic t_ptr;
        @(negedge clk);
        req_addr = 16'h0100; req_word = 1'b0; #1;
        chk(ptr_next == 16'h0101, "R10 byte step", ptr_next, 16'h0101);
        req_word = 1'b1; #1;
        chk(ptr_next == 16'h0102, "R10 word step", ptr_next, 16'h0102);
        req_addr = 16'hffff; req_word = 1'b0; #1;
        chk(ptr_next == 16'h0000, "R10 wrap", ptr_next, 16'h0000);
    endtask

    task automatic t_both;
        logic [15:0] q, ta; bit v, t;
        access(16'h0840, 1'b1, 1'b1, 1'b1, 16'hc0de, q, v, t, ta);
        chk(!v, "R12 read dropped", 16'(v), 16'h0);
        rd_chk(16'h0840, 1'b1, "R12 write done");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_fill();
        t_word_rw();
        t_byte_lanes();
        t_misaligned();
        t_holes();
        t_ptr();
        t_both();
        rd_chk(16'h0ffe, 1'b1, "R1 fill readback");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule